// File: doc/BRIEF.md
# Dual Byte FIFO with Trigger Interrupts

This block holds two byte queues between a register-side host and an I2C bus engine. The transmit queue is filled by the host and drained by the engine. The receive queue is filled by the engine and drained by the host. The queue depth is a parameter, normally 16 or 64. The host supplies a 32-bit control word that enables each queue and sets a 7-bit trigger level for each. The block returns a 32-bit status word that carries the fill levels and the full and empty flags.

Seven sticky interrupt status bits record the following:
- transmit almost-empty;
- receive almost-full;
- underrun and overrun, separately for each direction;
- a trailing-data timeout.

The trailing timeout fires when a small remainder of received bytes waits, untouched, for a programmed number of cycles. Each status bit has its own enable into the single interrupt line. The host clears status bits by presenting ones on a clear vector.

Each queue is tracked by a fill state machine with three states:
- FS_EMPTY goes to FS_PART on an accepted push, or straight to FS_FULL when the depth is 1.
- FS_PART goes to FS_FULL on a lone push at depth-1.
- FS_PART goes to FS_EMPTY on a lone pop at level 1.
- FS_FULL goes to FS_PART on a lone pop.
- Disabling a queue forces it to FS_EMPTY.

The trailing timer has three states:
- TS_IDLE, where the count is zero.
- TS_COUNT goes to TS_FIRED when the count reaches the programmed value.
- TS_IDLE goes to TS_FIRED directly when the programmed value is 1.
- Any of the three states returns to TS_IDLE on receive activity or when the timer is no longer armed.

Top module: `byte_fifo_irq`

## Requirements
- R1: After reset both queues are empty. The status word reads 0x0100_0100 (only the two empty flags set), all interrupt status bits are 0 and irq is 0.
- R2: Bytes leave each queue in the order they were accepted. The read-data outputs (eng_tx_data, host_rx_data) show the oldest byte, and the levels count the stored bytes.
- R3: A push into a full queue with no pop in the same cycle drops the byte and leaves the level unchanged. It sets the overrun bit: bit 3 for transmit, bit 5 for receive.
- R4: A pop from an empty queue returns 0x00, changes nothing and sets the underrun bit: bit 2 for transmit, bit 4 for receive.
- R5: Status word fields are as follows, and all other bits read 0:

  | Field | Bits |
  |---|---|
  | TX level | [6:0] |
  | TX full | 7 |
  | TX empty | 8 |
  | RX level | [22:16] |
  | RX full | 23 |
  | RX empty | 24 |

- R6: Control bit 0 enables the receive queue and bit 1 the transmit queue. A disabled queue is flushed to empty at the next edge, ignores pushes and pops, and raises none of its interrupt conditions.
- R7: Status bit 0 (almost-empty) is set in any cycle where transmit is enabled and the TX level is at or below the TX trigger, control bits [22:16].
- R8: Status bit 1 (almost-full) is set in any cycle where receive is enabled and the RX level is nonzero and at or above the RX trigger, control bits [10:4].
- R9: Status bit 6 (trailing) is set after trail_count consecutive cycles in which all of the following hold:
  - receive is enabled;
  - 0 < RX level < RX trigger;
  - no receive push or pop is requested.

  A push or pop restarts the count. It fires once per idle stretch, and a trail_count of 0 never fires.
- R10: Status bits are sticky and registered: a condition in cycle N shows after edge N. A one on irq_clear clears that bit at the edge, except when its condition is present in the same cycle, in which case the set wins.
- R11: irq is 1 exactly when some status bit and its irq_enable bit are both 1.
- R12: A push and a pop in the same cycle on a full queue are both accepted. The level stays at depth and no overrun is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ctrl_word | input | 32 | Queue enables and trigger levels |
| trail_count | input | 4 | Idle cycles before the trailing interrupt |
| irq_enable | input | 7 | Per-bit enable into irq |
| irq_clear | input | 7 | Write-one-to-clear strobes for status bits |
| host_tx_wr | input | 1 | Host pushes a byte into the transmit queue |
| host_tx_data | input | 8 | Byte pushed by the host |
| host_rx_rd | input | 1 | Host pops a byte from the receive queue |
| host_rx_data | output | 8 | Oldest received byte, 0 when empty |
| eng_tx_pop | input | 1 | Engine pops a byte from the transmit queue |
| eng_tx_data | output | 8 | Oldest transmit byte, 0 when empty |
| eng_rx_push | input | 1 | Engine pushes a received byte |
| eng_rx_data | input | 8 | Byte pushed by the engine |
| fifo_status | output | 32 | Levels and full/empty flags |
| irq_status | output | 7 | Sticky interrupt status |
| irq | output | 1 | Combined interrupt |

## Verification
The assertions assume that the depth is a power of two no larger than 64, so that each level fits its 7-bit field. They also assume that every strobe is a clean, registered level sampled on the clock edge, with no meaning attached to data inputs when their strobe is low.

The stimulus holds the depth at 16. It changes the control word only between cycles and draws the trigger levels from 0 to 17, so that both trigger extremes are reached without breaking those assumptions. Push and pop rates are skewed per phase so that both queues repeatedly reach full and empty, which drives overrun, underrun and the simultaneous full-queue push and pop.

// File: rtl/bfi_pkg.sv
package bfi_pkg;
    localparam int IRQ_W         = 7;
    localparam int IRQ_TX_AEMPTY = 0;
    localparam int IRQ_RX_AFULL  = 1;
    localparam int IRQ_TX_UNDER  = 2;
    localparam int IRQ_TX_OVER   = 3;
    localparam int IRQ_RX_UNDER  = 4;
    localparam int IRQ_RX_OVER   = 5;
    localparam int IRQ_TRAIL     = 6;
    localparam int TRIG_W        = 7;
    localparam int TCNT_W        = 4;

    typedef enum logic [1:0] {
        FS_EMPTY = 2'd0,
        FS_PART  = 2'd1,
        FS_FULL  = 2'd2
    } fill_state_e;

    typedef enum logic [1:0] {
        TS_IDLE  = 2'd0,
        TS_COUNT = 2'd1,
        TS_FIRED = 2'd2
    } trail_state_e;

    typedef struct packed {
        logic overrun;
        logic underrun;
    } fifo_err_t;
endpackage

// File: rtl/bfi_fifo_core.sv
module bfi_fifo_core
    import bfi_pkg::*;
#(
    parameter int DEPTH = 16,
    parameter int LVLW  = $clog2(DEPTH + 1)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            en,
    input  logic            push,
    input  logic [7:0]      push_data,
    input  logic            pop,
    output logic [7:0]      pop_data,
    output logic [LVLW-1:0] level,
    output logic            full,
    output logic            empty,
    output fifo_err_t       err
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam logic [LVLW-1:0] DEPTH_L = LVLW'(DEPTH);
    localparam logic [AW-1:0]   LAST_A  = AW'(DEPTH - 1);

    fill_state_e     state_q, state_d;
    logic [AW-1:0]   rd_q, wr_q;
    logic [LVLW-1:0] lvl_q, lvl_d;
    logic [7:0]      mem [DEPTH];
    logic            pop_ok, push_ok;

    always_comb begin
        pop_ok       = en & pop & (state_q != FS_EMPTY);
        push_ok      = en & push & ((state_q != FS_FULL) | pop_ok);
        err.underrun = en & pop & (state_q == FS_EMPTY);
        err.overrun  = en & push & ~push_ok;
    end

    always_comb begin
        lvl_d = lvl_q;
        if (!en)
            lvl_d = '0;
        else if (push_ok && !pop_ok)
            lvl_d = lvl_q + 1'b1;
        else if (pop_ok && !push_ok)
            lvl_d = lvl_q - 1'b1;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            FS_EMPTY: begin
                if (push_ok)
                    state_d = (DEPTH_L == 1) ? FS_FULL : FS_PART;
            end
            FS_PART: begin
                if (push_ok && !pop_ok && lvl_q == DEPTH_L - 1'b1)
                    state_d = FS_FULL;
                else if (pop_ok && !push_ok && lvl_q == 1)
                    state_d = FS_EMPTY;
            end
            FS_FULL: begin
                if (pop_ok && !push_ok)
                    state_d = (DEPTH_L == 1) ? FS_EMPTY : FS_PART;
            end
            default: state_d = FS_EMPTY;
        endcase
        if (!en)
            state_d = FS_EMPTY;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= FS_EMPTY;
            lvl_q   <= '0;
            rd_q    <= '0;
            wr_q    <= '0;
        end else begin
            state_q <= state_d;
            lvl_q   <= lvl_d;
            if (!en) begin
                rd_q <= '0;
                wr_q <= '0;
            end else begin
                if (pop_ok)
                    rd_q <= (rd_q == LAST_A) ? '0 : rd_q + 1'b1;
                if (push_ok)
                    wr_q <= (wr_q == LAST_A) ? '0 : wr_q + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (push_ok)
            mem[wr_q] <= push_data;
    end

    always_comb begin
        level    = lvl_q;
        full     = (state_q == FS_FULL);
        empty    = (state_q == FS_EMPTY);
        pop_data = empty ? 8'h00 : mem[rd_q];
    end

    // R5: the fill state and the level counter agree
    p_state_level_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (empty == (level == 0)) && (full == (level == DEPTH_L)));

    // R3: a dropped byte leaves the queue at depth
    p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (en && push && full && !pop) |=> (level == DEPTH_L));

    // R4: a pop from an empty queue does not move the level
    p_underrun_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (en && pop && empty && !push) |=> (level == 0));

    // R6: a disabled queue is flushed
    p_disable_flush_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> (level == 0));

    // R12: a push and a pop on a full queue keep it full
    p_full_swap_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (en && push && pop && full) |=> (level == DEPTH_L));
endmodule

// File: rtl/bfi_trail_timer.sv
module bfi_trail_timer
    import bfi_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              armed,
    input  logic              activity,
    input  logic [TCNT_W-1:0] limit,
    output logic              fire
);
    trail_state_e      state_q, state_d;
    logic [TCNT_W-1:0] cnt_q, cnt_d, cnt_inc;
    logic              reach;

    always_comb begin
        cnt_inc = (cnt_q == {TCNT_W{1'b1}}) ? cnt_q : cnt_q + 1'b1;
        reach   = (limit != '0) &&
                  (({1'b0, cnt_q} + 1'b1) == {1'b0, limit});
    end

    always_comb begin
        fire = (state_q != TS_FIRED) && armed && !activity && reach;
    end

    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            TS_IDLE, TS_COUNT: begin
                if (!armed || activity) begin
                    state_d = TS_IDLE;
                    cnt_d   = '0;
                end else if (reach) begin
                    state_d = TS_FIRED;
                    cnt_d   = cnt_inc;
                end else begin
                    state_d = TS_COUNT;
                    cnt_d   = cnt_inc;
                end
            end
            TS_FIRED: begin
                if (!armed || activity) begin
                    state_d = TS_IDLE;
                    cnt_d   = '0;
                end
            end
            default: begin
                state_d = TS_IDLE;
                cnt_d   = '0;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= TS_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    // R9: fires once per idle stretch
    p_fire_once_r9: assert property (@(posedge clk) disable iff (!rst_n)
        fire |=> !fire);

    // R9: activity restarts the count
    p_restart_r9: assert property (@(posedge clk) disable iff (!rst_n)
        activity |=> (cnt_q == '0));
endmodule

// File: rtl/bfi_irq_status.sv
module bfi_irq_status
    import bfi_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IRQ_W-1:0] set_i,
    input  logic [IRQ_W-1:0] clear_i,
    input  logic [IRQ_W-1:0] enable_i,
    output logic [IRQ_W-1:0] status_o,
    output logic             irq_o
);
    logic [IRQ_W-1:0] st_q;

    for (genvar k = 0; k < IRQ_W; k++) begin : g_bit
        always_ff @(posedge clk) begin
            if (!rst_n)
                st_q[k] <= 1'b0;
            else if (set_i[k])
                st_q[k] <= 1'b1;
            else if (clear_i[k])
                st_q[k] <= 1'b0;
        end

        // R10: a clear with no concurrent set empties the bit
        p_w1c_r10: assert property (@(posedge clk) disable iff (!rst_n)
            (clear_i[k] && !set_i[k]) |=> !status_o[k]);

        // R10: a bit holds until cleared
        p_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
            (status_o[k] && !clear_i[k]) |=> status_o[k]);

        // R10: a set always lands
        p_set_wins_r10: assert property (@(posedge clk) disable iff (!rst_n)
            set_i[k] |=> status_o[k]);
    end

    always_comb begin
        status_o = st_q;
        irq_o    = |(st_q & enable_i);
    end
endmodule

// File: rtl/byte_fifo_irq.sv
module byte_fifo_irq
    import bfi_pkg::*;
#(
    parameter int DEPTH = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [31:0]       ctrl_word,
    input  logic [TCNT_W-1:0] trail_count,
    input  logic [IRQ_W-1:0]  irq_enable,
    input  logic [IRQ_W-1:0]  irq_clear,
    input  logic              host_tx_wr,
    input  logic [7:0]        host_tx_data,
    input  logic              host_rx_rd,
    output logic [7:0]        host_rx_data,
    input  logic              eng_tx_pop,
    output logic [7:0]        eng_tx_data,
    input  logic              eng_rx_push,
    input  logic [7:0]        eng_rx_data,
    output logic [31:0]       fifo_status,
    output logic [IRQ_W-1:0]  irq_status,
    output logic              irq
);
    localparam int LVLW = $clog2(DEPTH + 1);
    localparam int NQ   = 2;
    localparam int QTX  = 0;
    localparam int QRX  = 1;

    logic [TRIG_W-1:0] tx_trig, rx_trig;
    logic              unused_ctrl;
    logic [NQ-1:0]     q_en, q_push, q_pop, q_full, q_empty;
    logic [7:0]        q_wdata [NQ];
    logic [7:0]        q_rdata [NQ];
    logic [LVLW-1:0]   q_lvl   [NQ];
    fifo_err_t         q_err   [NQ];
    logic [TRIG_W-1:0] tx_lvl7, rx_lvl7;
    logic              armed, rx_act, trail_fire;
    logic [IRQ_W-1:0]  irq_set;

    always_comb begin
        q_en[QRX]    = ctrl_word[0];
        q_en[QTX]    = ctrl_word[1];
        rx_trig      = ctrl_word[10:4];
        tx_trig      = ctrl_word[22:16];
        unused_ctrl  = ^{ctrl_word[31:23], ctrl_word[15:11], ctrl_word[3:2]};
        q_push[QTX]  = host_tx_wr;
        q_wdata[QTX] = host_tx_data;
        q_pop[QTX]   = eng_tx_pop;
        q_push[QRX]  = eng_rx_push;
        q_wdata[QRX] = eng_rx_data;
        q_pop[QRX]   = host_rx_rd;
    end

    for (genvar q = 0; q < NQ; q++) begin : g_q
        bfi_fifo_core #(.DEPTH(DEPTH), .LVLW(LVLW)) u_core (
            .clk       (clk),
            .rst_n     (rst_n),
            .en        (q_en[q]),
            .push      (q_push[q]),
            .push_data (q_wdata[q]),
            .pop       (q_pop[q]),
            .pop_data  (q_rdata[q]),
            .level     (q_lvl[q]),
            .full      (q_full[q]),
            .empty     (q_empty[q]),
            .err       (q_err[q])
        );
    end

    always_comb begin
        tx_lvl7 = TRIG_W'(q_lvl[QTX]);
        rx_lvl7 = TRIG_W'(q_lvl[QRX]);
        armed   = q_en[QRX] && (rx_lvl7 != '0) && (rx_lvl7 < rx_trig);
        rx_act  = q_en[QRX] && (eng_rx_push || host_rx_rd);
    end

    bfi_trail_timer u_trail (
        .clk      (clk),
        .rst_n    (rst_n),
        .armed    (armed),
        .activity (rx_act),
        .limit    (trail_count),
        .fire     (trail_fire)
    );

    always_comb begin
        irq_set                = '0;
        irq_set[IRQ_TX_AEMPTY] = q_en[QTX] && (tx_lvl7 <= tx_trig);
        irq_set[IRQ_RX_AFULL]  = q_en[QRX] && (rx_lvl7 != '0) && (rx_lvl7 >= rx_trig);
        irq_set[IRQ_TX_UNDER]  = q_err[QTX].underrun;
        irq_set[IRQ_TX_OVER]   = q_err[QTX].overrun;
        irq_set[IRQ_RX_UNDER]  = q_err[QRX].underrun;
        irq_set[IRQ_RX_OVER]   = q_err[QRX].overrun;
        irq_set[IRQ_TRAIL]     = trail_fire;
    end

    bfi_irq_status u_irq (
        .clk      (clk),
        .rst_n    (rst_n),
        .set_i    (irq_set),
        .clear_i  (irq_clear),
        .enable_i (irq_enable),
        .status_o (irq_status),
        .irq_o    (irq)
    );

    always_comb begin
        fifo_status        = '0;
        fifo_status[6:0]   = tx_lvl7;
        fifo_status[7]     = q_full[QTX];
        fifo_status[8]     = q_empty[QTX];
        fifo_status[22:16] = rx_lvl7;
        fifo_status[23]    = q_full[QRX];
        fifo_status[24]    = q_empty[QRX];
        eng_tx_data        = q_rdata[QTX];
        host_rx_data       = q_rdata[QRX];
    end

    // R6: a disabled transmit queue raises no transmit error
    p_tx_off_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !ctrl_word[1] |=> !(irq_status[IRQ_TX_OVER] && !$past(irq_status[IRQ_TX_OVER])));

    // R8: almost-full never comes from an empty receive queue
    p_afull_nonempty_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (q_en[QRX] && q_empty[QRX] && !irq_status[IRQ_RX_AFULL]) |=> !irq_status[IRQ_RX_AFULL]);
endmodule

// File: tb/sim_byte_fifo_irq.sv
module sim_byte_fifo_irq;
    localparam int CLK_PERIOD = 10;
    localparam int DEPTH      = 16;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [31:0] ctrl_word;
    logic [3:0]  trail_count;
    logic [6:0]  irq_enable, irq_clear;
    logic        host_tx_wr, host_rx_rd, eng_tx_pop, eng_rx_push;
    logic [7:0]  host_tx_data, eng_rx_data, host_rx_data, eng_tx_data;
    logic [31:0] fifo_status;
    logic [6:0]  irq_status;
    logic        irq;

    int checks = 0;
    int errors = 0;
    bit done   = 0;

    byte_fifo_irq #(.DEPTH(DEPTH)) u0 (
        .clk(clk), .rst_n(rst_n), .ctrl_word(ctrl_word), .trail_count(trail_count),
        .irq_enable(irq_enable), .irq_clear(irq_clear),
        .host_tx_wr(host_tx_wr), .host_tx_data(host_tx_data),
        .host_rx_rd(host_rx_rd), .host_rx_data(host_rx_data),
        .eng_tx_pop(eng_tx_pop), .eng_tx_data(eng_tx_data),
        .eng_rx_push(eng_rx_push), .eng_rx_data(eng_rx_data),
        .fifo_status(fifo_status), .irq_status(irq_status), .irq(irq)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    // reference model state
    logic [7:0] m_q [2][64];
    int         m_n [2];
    logic [6:0] m_st;
    int         m_tc;
    bit         m_fired;
    logic [6:0] m_set;
    bit         m_und, m_ovr, m_armed, m_act;

    task automatic fstep(input int d, input bit en, input bit push, input logic [7:0] data,
                         input bit pop, output bit und, output bit ovr);
        bit pop_ok, push_ok;
        und = 0;
        ovr = 0;
        if (!en) begin
            m_n[d] = 0;
            return;
        end
        pop_ok  = pop && (m_n[d] > 0);
        und     = pop && (m_n[d] == 0);
        push_ok = push && ((m_n[d] < DEPTH) || pop_ok);
        ovr     = push && !push_ok;
        if (pop_ok) begin
            for (int i = 0; i < 63; i++) m_q[d][i] = m_q[d][i+1];
            m_n[d] = m_n[d] - 1;
        end
        if (push_ok) begin
            m_q[d][m_n[d]] = data;
            m_n[d] = m_n[d] + 1;
        end
    endtask

    always @(posedge clk) begin
        if (!rst_n) begin
            m_n[0] = 0; m_n[1] = 0; m_st = '0; m_tc = 0; m_fired = 0;
        end else begin
            m_set = '0;
            if (ctrl_word[1] && m_n[0] <= int'(ctrl_word[22:16])) m_set[0] = 1;
            if (ctrl_word[0] && m_n[1] != 0 && m_n[1] >= int'(ctrl_word[10:4])) m_set[1] = 1;
            m_armed = ctrl_word[0] && m_n[1] != 0 && m_n[1] < int'(ctrl_word[10:4]);
            m_act   = ctrl_word[0] && (eng_rx_push || host_rx_rd);
            if (!m_armed || m_act) begin
                m_tc = 0; m_fired = 0;
            end else if (!m_fired) begin
                if (trail_count != 0 && m_tc + 1 == int'(trail_count)) begin
                    m_set[6] = 1; m_fired = 1;
                end
                m_tc = (m_tc == 15) ? 15 : m_tc + 1;
            end
            fstep(0, ctrl_word[1], host_tx_wr, host_tx_data, eng_tx_pop, m_und, m_ovr);
            m_set[2] = m_und; m_set[3] = m_ovr;
            fstep(1, ctrl_word[0], eng_rx_push, eng_rx_data, host_rx_rd, m_und, m_ovr);
            m_set[4] = m_und; m_set[5] = m_ovr;
            m_st = (m_st & ~irq_clear) | m_set;
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic compare_all();
        chk("R2 tx level", {25'd0, fifo_status[6:0]}, m_n[0]);
        chk("R2 rx level", {25'd0, fifo_status[22:16]}, m_n[1]);
        chk("R5 tx full", {31'd0, fifo_status[7]}, {31'd0, m_n[0] == DEPTH});
        chk("R5 tx empty", {31'd0, fifo_status[8]}, {31'd0, m_n[0] == 0});
        chk("R5 rx full", {31'd0, fifo_status[23]}, {31'd0, m_n[1] == DEPTH});
        chk("R5 rx empty", {31'd0, fifo_status[24]}, {31'd0, m_n[1] == 0});
        chk("R5 reserved", {fifo_status[31:25], fifo_status[15:9]}, 0);
        chk("R2 tx head", {24'd0, eng_tx_data}, (m_n[0] > 0) ? {24'd0, m_q[0][0]} : 0);
        chk("R4 rx head", {24'd0, host_rx_data}, (m_n[1] > 0) ? {24'd0, m_q[1][0]} : 0);
        chk("R7 aempty", {31'd0, irq_status[0]}, {31'd0, m_st[0]});
        chk("R8 afull", {31'd0, irq_status[1]}, {31'd0, m_st[1]});
        chk("R4 tx under", {31'd0, irq_status[2]}, {31'd0, m_st[2]});
        chk("R3 tx over", {31'd0, irq_status[3]}, {31'd0, m_st[3]});
        chk("R4 rx under", {31'd0, irq_status[4]}, {31'd0, m_st[4]});
        chk("R3 rx over", {31'd0, irq_status[5]}, {31'd0, m_st[5]});
        chk("R9 trailing", {31'd0, irq_status[6]}, {31'd0, m_st[6]});
        chk("R11 irq", {31'd0, irq}, {31'd0, |(m_st & irq_enable)});
    endtask

    task automatic step();
        @(posedge clk);
        #1;
        compare_all();
        host_tx_wr  = 0;
        host_rx_rd  = 0;
        eng_tx_pop  = 0;
        eng_rx_push = 0;
        irq_clear   = '0;
    endtask

    function automatic logic [31:0] mk_ctrl(input bit rx_en, input bit tx_en,
                                            input int rx_t, input int tx_t);
        return (32'(tx_t & 7'h7F) << 16) | (32'(rx_t & 7'h7F) << 4) |
               (32'(tx_en) << 1) | 32'(rx_en);
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual hung expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        int seed;
        seed = 32'h1A2B3C;
        void'($urandom(seed));
        rst_n = 0; ctrl_word = '0; trail_count = '0; irq_enable = '0; irq_clear = '0;
        host_tx_wr = 0; host_tx_data = '0; host_rx_rd = 0;
        eng_tx_pop = 0; eng_rx_push = 0; eng_rx_data = '0;
        repeat (3) @(posedge clk);
        #1;
        rst_n = 1;
        step();
        chk("R1 status word", fifo_status, 32'h0100_0100);
        chk("R1 irq status", {25'd0, irq_status}, 0);
        chk("R1 irq", {31'd0, irq}, 0);

        ctrl_word = mk_ctrl(1, 1, 4, 2);
        trail_count = 4'd5;
        irq_enable = 7'h7F;
        for (int i = 0; i < 5; i++) begin
            host_tx_wr = 1; host_tx_data = 8'hA0 + 8'(i);
            step();
        end
        chk("R2 five stored", {25'd0, fifo_status[6:0]}, 5);
        for (int i = 0; i < 5; i++) begin
            chk("R2 oldest byte", {24'd0, eng_tx_data}, 32'hA0 + i);
            eng_tx_pop = 1;
            step();
        end

        for (int i = 0; i < DEPTH; i++) begin
            host_tx_wr = 1; host_tx_data = 8'h10 + 8'(i);
            step();
        end
        host_tx_wr = 1; host_tx_data = 8'hEE;
        step();
        chk("R3 level held", {25'd0, fifo_status[6:0]}, DEPTH);
        chk("R3 overrun bit", {31'd0, irq_status[3]}, 1);
        irq_clear = 7'h7F;
        step();
        host_tx_wr = 1; host_tx_data = 8'h55; eng_tx_pop = 1;
        step();
        chk("R12 level full", {25'd0, fifo_status[6:0]}, DEPTH);
        chk("R12 no overrun", {31'd0, irq_status[3]}, 0);
        for (int i = 0; i < DEPTH; i++) begin
            eng_tx_pop = 1;
            step();
        end
        chk("R4 empty data", {24'd0, eng_tx_data}, 0);
        eng_tx_pop = 1;
        step();
        chk("R4 underrun bit", {31'd0, irq_status[2]}, 1);

        irq_clear = 7'h7F;
        step();
        for (int i = 0; i < 2; i++) begin
            eng_rx_push = 1; eng_rx_data = 8'hC0 + 8'(i);
            step();
        end
        for (int i = 0; i < 4; i++) step();
        chk("R9 not yet", {31'd0, irq_status[6]}, 0);
        step();
        chk("R9 fired", {31'd0, irq_status[6]}, 1);
        for (int i = 0; i < 3; i++) step();
        chk("R9 fires once", {31'd0, irq_status[6]}, 1);

        for (int i = 0; i < 2; i++) begin
            eng_rx_push = 1; eng_rx_data = 8'hC2 + 8'(i);
            step();
        end
        chk("R8 not yet", {31'd0, irq_status[1]}, 0);
        step();
        chk("R8 afull", {31'd0, irq_status[1]}, 1);

        irq_clear = 7'h01;
        step();
        chk("R10 set wins", {31'd0, irq_status[0]}, 1);
        irq_clear = 7'h40;
        step();
        chk("R10 cleared", {31'd0, irq_status[6]}, 0);
        irq_enable = '0;
        step();
        chk("R11 masked", {31'd0, irq}, 0);
        irq_enable = 7'h02;
        step();
        chk("R11 enabled", {31'd0, irq}, 1);

        for (int i = 0; i < 3; i++) begin
            host_tx_wr = 1; host_tx_data = 8'h70 + 8'(i);
            step();
        end
        ctrl_word = mk_ctrl(1, 0, 4, 2);
        irq_clear = 7'h7F;
        step();
        chk("R6 flushed", {25'd0, fifo_status[6:0]}, 0);
        host_tx_wr = 1; host_tx_data = 8'h99; eng_tx_pop = 1;
        step();
        chk("R6 push ignored", {25'd0, fifo_status[6:0]}, 0);
        chk("R6 no flags", {25'd0, irq_status & 7'h0D}, 0);

        for (int ph = 0; ph < 12; ph++) begin
            int push_p, pop_p;
            ctrl_word   = mk_ctrl(1, 1, $urandom_range(0, 17), $urandom_range(0, 17));
            trail_count = 4'($urandom_range(0, 15));
            irq_enable  = 7'($urandom);
            push_p = (ph % 3 == 0) ? 80 : ((ph % 3 == 1) ? 20 : 50);
            pop_p  = 100 - push_p;
            for (int c = 0; c < 200; c++) begin
                host_tx_wr   = ($urandom_range(0, 99) < push_p);
                host_tx_data = 8'($urandom);
                eng_tx_pop   = ($urandom_range(0, 99) < pop_p);
                eng_rx_push  = ($urandom_range(0, 99) < push_p / 2);
                eng_rx_data  = 8'($urandom);
                host_rx_rd   = ($urandom_range(0, 99) < pop_p / 3);
                if ($urandom_range(0, 7) == 0) irq_clear = 7'($urandom);
                if ($urandom_range(0, 63) == 0) ctrl_word[$urandom_range(0, 1)] = 1'b0;
                else if ($urandom_range(0, 7) == 0) ctrl_word[1:0] = 2'b11;
                step();
            end
        end

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule